// File: doc/BRIEF.md
# Transceiver Register Access SPI Master

This block is a dedicated SPI master for reading and writing the 8-bit configuration registers of a radio transceiver. Each accepted request turns into exactly one access on the serial pins: a command byte (direction flag plus 7-bit register address) and a data byte, shifted back to back while the active-low enable line is held low. No dead time is inserted between enable assertion and the first clock, nor between the two bytes. The transceiver applies a written value when the enable line returns high.

A requester presents a read/write flag, an address and write data with a valid strobe and waits for the ready handshake. The block reports `busy` while the access is in flight and pulses `done` for one cycle when the enable line rises, with the byte shifted in during the data phase available on `rd_data`. That byte is what firmware uses as the read half of a read-modify-write sequence. The serial clock is the system clock divided by `2*HALF_DIV`. With a 250 MHz system clock and the default `HALF_DIV` of 6, this gives about 20.8 MHz, and a whole access takes 768 ns.

Top module: `trx_reg_spi`

## Requirements
- R1: An accepted request produces a 16-bit frame on `spi_mosi`, sent MSB first. Bit 15 is the direction flag (1 = write, 0 = read), bits 14:8 are the register address and bits 7:0 are the write data.
- R2: `spi_sclk` is low whenever `spi_sen_n` is high and toggles only while it is low. `spi_mosi` changes only on falling `spi_sclk` and is stable while `spi_sclk` is high. `spi_miso` is sampled on rising `spi_sclk`. `spi_sclk` is low when `spi_sen_n` rises.
- R3: Every access has exactly 16 rising `spi_sclk` edges, each 2*HALF_DIV system cycles after the previous one, with no gap between the command byte and the data byte.
- R4: The first rising `spi_sclk` comes HALF_DIV cycles after `spi_sen_n` falls. `spi_sen_n` rises at the falling edge after the 16th rising edge, so it is low for exactly 32*HALF_DIV cycles.
- R5: When `done` is high, `rd_data` holds the eight `spi_miso` bits sampled on rising edges 9 to 16, first-sampled bit in bit 7.
- R6: `done` is high for exactly one cycle, the same cycle in which `spi_sen_n` first reads high again.
- R7: A request is taken on a rising clock edge with `req_valid` and `req_ready` both high, and `spi_sen_n` falls at that edge. `busy` is high from that edge until `spi_sen_n` rises. `req_ready` is low whenever `busy` is high. Request inputs presented while busy do not start or alter an access.
- R8: After `spi_sen_n` rises, `req_ready` stays low for 2*HALF_DIV cycles, so `spi_sen_n` stays high for at least 2*HALF_DIV cycles between accesses.
- R9: After reset, `spi_sen_n` is high, `spi_sclk` is low, `busy` and `done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte received in the data phase |
| spi_sen_n | output | 1 | Active-low enable to the transceiver |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the transceiver |
| spi_miso | input | 1 | Serial data from the transceiver |

## Verification
The bench targets the following corner cases and the failures each one would expose:
- **Byte boundary.** A design that inserted a stall between the command byte and the data byte would show a stretched clock interval at edge 9 and a longer enable window.
- **Leading and trailing edges of the enable window.** An off-by-one counter would move the first rising clock or the enable rise by a cycle, or leave the clock high at the end.
- **Request held asserted with changing fields while busy.** A design that sampled the inputs late or re-armed early would send a corrupted frame or start a second access.
- **Back-to-back requests.** These expose a missing minimum enable-high gap.
- **Read-back of a byte just written.** The extreme addresses and the all-ones and all-zeros patterns catch wrong bit order and wrong capture of the data phase.

// File: rtl/trx_spi_pkg.sv
package trx_spi_pkg;

    localparam int ADDR_W      = 7;
    localparam int DATA_W      = 8;
    localparam int FRAME_W     = 1 + ADDR_W + DATA_W;
    localparam int GUARD_TICKS = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GUARD
    } spi_state_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    function automatic logic [FRAME_W-1:0] pack_frame(input reg_req_t r);
        return {r.wr, r.addr, r.wdata};
    endfunction

endpackage

// File: rtl/trx_spi_tick.sv
module trx_spi_tick #(
    parameter int HALF_DIV = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (HALF_DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt_q;

            assign tick = run && (cnt_q == LAST);

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt_q <= '0;
                end else if (tick) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/trx_spi_ctrl.sv
module trx_spi_ctrl
    import trx_spi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic tick,
    output logic req_ready,
    output logic busy,
    output logic run,
    output logic load,
    output logic shift_en,
    output logic sample_en,
    output logic finish,
    output logic sen_n,
    output logic sclk
);
    localparam int BCW = $clog2(FRAME_W + 1);
    localparam int GCW = $clog2(GUARD_TICKS + 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_W);
    localparam logic [GCW-1:0] LAST_GD  = GCW'(GUARD_TICKS - 1);

    spi_state_e     state_q;
    logic           sclk_q;
    logic           sen_n_q;
    logic [BCW-1:0] bit_cnt_q;
    logic [GCW-1:0] gd_cnt_q;
    logic           rise_ev;
    logic           fall_ev;
    logic           all_bits;

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        busy      = (state_q == ST_SHIFT);
        run       = (state_q != ST_IDLE);
        load      = req_ready && req_valid;
        rise_ev   = busy && tick && !sclk_q;
        fall_ev   = busy && tick && sclk_q;
        all_bits  = (bit_cnt_q == LAST_BIT);
        sample_en = rise_ev;
        shift_en  = fall_ev && !all_bits;
        finish    = fall_ev && all_bits;
    end

    assign sen_n = sen_n_q;
    assign sclk  = sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            sclk_q    <= 1'b0;
            sen_n_q   <= 1'b1;
            bit_cnt_q <= '0;
            gd_cnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (load) begin
                        state_q   <= ST_SHIFT;
                        sen_n_q   <= 1'b0;
                        bit_cnt_q <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (rise_ev) begin
                        sclk_q    <= 1'b1;
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                    if (fall_ev) begin
                        sclk_q <= 1'b0;
                    end
                    if (finish) begin
                        sen_n_q  <= 1'b1;
                        state_q  <= ST_GUARD;
                        gd_cnt_q <= '0;
                    end
                end
                ST_GUARD: begin
                    if (tick) begin
                        gd_cnt_q <= gd_cnt_q + 1'b1;
                        if (gd_cnt_q == LAST_GD) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/trx_spi_shifter.sv
module trx_spi_shifter
    import trx_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  reg_req_t          req,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              finish,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    logic [FRAME_W-1:0] tx_q;
    logic [DATA_W-1:0]  rx_q;
    logic [DATA_W-1:0]  rd_q;
    logic               done_q;

    assign mosi    = tx_q[FRAME_W-1];
    assign rd_data = rd_q;
    assign done    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            rx_q   <= '0;
            rd_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (load) begin
                tx_q <= pack_frame(req);
            end else if (shift_en) begin
                tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            end else if (finish) begin
                tx_q <= '0;
            end
            if (sample_en) begin
                rx_q <= {rx_q[DATA_W-2:0], miso};
            end
            if (finish) begin
                rd_q <= rx_q;
            end
        end
    end
endmodule

// File: rtl/trx_reg_spi.sv
module trx_reg_spi
    import trx_spi_pkg::*;
#(
    parameter int HALF_DIV = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              spi_sen_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic     run;
    logic     tick;
    logic     load;
    logic     shift_en;
    logic     sample_en;
    logic     finish;
    reg_req_t req;

    assign req = '{wr: req_write, addr: req_addr, wdata: req_wdata};

    trx_spi_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    trx_spi_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .tick      (tick),
        .req_ready (req_ready),
        .busy      (busy),
        .run       (run),
        .load      (load),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .finish    (finish),
        .sen_n     (spi_sen_n),
        .sclk      (spi_sclk)
    );

    trx_spi_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .req       (req),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .finish    (finish),
        .miso      (spi_miso),
        .mosi      (spi_mosi),
        .rd_data   (rd_data),
        .done      (done)
    );
endmodule

// File: rtl/trx_reg_spi_chk.sv
module trx_reg_spi_chk
    import trx_spi_pkg::*;
#(
    parameter int HALF_DIV = 6
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic busy,
    input logic done,
    input logic spi_sen_n,
    input logic spi_sclk,
    input logic spi_mosi
);
    localparam int MIN_GAP = 2 * HALF_DIV;
    localparam int WINDOW  = 2 * HALF_DIV * FRAME_W;

    logic [15:0] hi_cnt;
    logic [15:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '1;
            lo_cnt <= '0;
        end else begin
            if (!spi_sen_n) begin
                hi_cnt <= '0;
                lo_cnt <= lo_cnt + 1'b1;
            end else begin
                lo_cnt <= '0;
                if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
            end
        end
    end

    assert_start_on_accept_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_sen_n) |-> $past(req_valid && req_ready));
    assert_ready_only_idle_R7: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (spi_sen_n && !busy));
    assert_busy_in_window_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !spi_sen_n);
    assert_sclk_framed_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sclk) |-> !spi_sen_n);
    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
    assert_sclk_low_at_end_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sen_n) |-> !spi_sclk);
    assert_window_length_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sen_n) |-> (lo_cnt == 16'(WINDOW)));
    assert_done_on_release_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> $rose(spi_sen_n));
    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_min_gap_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_sen_n) |-> (hi_cnt >= 16'(MIN_GAP)));
endmodule

bind trx_reg_spi trx_reg_spi_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .spi_sen_n (spi_sen_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi)
);

// File: tb/tb_trx_reg_spi.sv
module tb_trx_reg_spi;
    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [6:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       busy;
    logic       done;
    logic [7:0] rd_data;
    logic       spi_sen_n;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso = 1'b0;

    always #2 clk = ~clk;

    trx_reg_spi #(.HALF_DIV(H)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .spi_sen_n(spi_sen_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0]  mem [128];
    logic [15:0] exp_frame;
    logic        exp_wr;
    logic [6:0]  exp_addr;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] make_frame(input logic w, input logic [6:0] a, input logic [7:0] d);
        return {w, a, d};
    endfunction

    // slave model and timing monitor, all sampled on the falling system edge
    int   cyc = 0;
    int   t_fall = 0, t_last = 0, t_up = 0, n_rise = 0;
    bit   seen_up = 0;
    logic prev_sen = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;
    logic [15:0] frame;
    logic [6:0]  cur_addr;
    logic        cur_wr;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (prev_sen && !spi_sen_n) begin
                t_fall = cyc; n_rise = 0; frame = '0; spi_miso = 1'b0;
                if (seen_up) chk((cyc - t_up) >= 2*H, "R8 enable high gap", cyc - t_up, 2*H);
            end
            if (!prev_sclk && spi_sclk) begin
                if (n_rise == 0) chk((cyc - t_fall) == H, "R4 first clock delay", cyc - t_fall, H);
                else chk((cyc - t_last) == 2*H, "R3 clock interval", cyc - t_last, 2*H);
                frame = {frame[14:0], spi_mosi};
                n_rise++;
                t_last = cyc;
                if (n_rise == 8) begin cur_wr = frame[7]; cur_addr = frame[6:0]; end
            end
            if (prev_sclk && spi_sclk && (spi_mosi !== prev_mosi))
                chk(0, "R2 mosi moved while clock high", spi_mosi, prev_mosi);
            if (prev_sclk && !spi_sclk && !spi_sen_n && n_rise >= 8 && n_rise < 16)
                spi_miso = cur_wr ? 1'b0 : mem[cur_addr][15 - n_rise];
            if (!prev_sen && spi_sen_n) begin
                chk(n_rise == 16, "R3 rising edge count", n_rise, 16);
                chk((cyc - t_fall) == 32*H, "R4 enable window", cyc - t_fall, 32*H);
                chk(!spi_sclk, "R2 clock low at release", spi_sclk, 0);
                chk(done == 1'b1, "R6 done with release", done, 1);
                chk(frame == exp_frame, "R1 frame content", frame, exp_frame);
                if (exp_wr) mem[exp_addr] = exp_frame[7:0];
                else chk(rd_data == mem[exp_addr], "R5 read data", rd_data, mem[exp_addr]);
                t_up = cyc; seen_up = 1;
            end else if (done) begin
                chk(0, "R6 done without release", done, 0);
            end
            if (prev_sen && spi_sen_n && done) chk(0, "R6 done held", done, 0);
            prev_sen = spi_sen_n; prev_sclk = spi_sclk; prev_mosi = spi_mosi;
        end
    end

    task automatic access(input logic w, input logic [6:0] a, input logic [7:0] d, input bit hold);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        exp_frame = make_frame(w, a, d); exp_wr = w; exp_addr = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        chk(busy && !req_ready, "R7 busy after accept", {busy, req_ready}, 2'b10);
        if (hold) begin
            req_write = ~w; req_addr = a ^ 7'h7F; req_wdata = d ^ 8'hFF;
        end else begin
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        req_valid = 1'b0;
        chk(!busy, "R7 busy cleared at release", busy, 0);
        chk(!req_ready, "R8 ready held low after release", req_ready, 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'h5A;
        void'($urandom(32'd20150706));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_sen_n && !spi_sclk && !busy && !done && req_ready, "R9 reset state",
            {spi_sen_n, spi_sclk, busy, done, req_ready}, 5'b10001);

        access(1'b1, 7'h7F, 8'hFF, 0);
        access(1'b0, 7'h7F, 8'h00, 0);
        access(1'b1, 7'h00, 8'h00, 0);
        access(1'b0, 7'h00, 8'hFF, 0);
        access(1'b1, 7'h55, 8'hAA, 1);
        access(1'b0, 7'h55, 8'h00, 1);
        access(1'b0, 7'h03, 8'h00, 0);
        access(1'b1, 7'h03, mem[3] | 8'h81, 0);
        access(1'b0, 7'h03, 8'h00, 0);
        for (int k = 0; k < 40; k++) begin
            logic       w;
            logic [6:0] a;
            logic [7:0] d;
            bit         hold;
            w = 1'($urandom % 2);
            a = 7'($urandom % 128);
            d = 8'($urandom % 256);
            hold = (($urandom % 4) == 0);
            access(w, a, d, hold);
        end
        repeat (4*H) @(negedge clk);
        chk(req_ready && spi_sen_n && !busy, "R7 idle after traffic",
            {req_ready, spi_sen_n, busy}, 3'b110);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule